// File: doc/BRIEF.md
# Two-Channel Prescaled PWM Controller

This block generates pulse-width-modulated waveforms on two independent output pins. Each channel first divides the system clock by a programmable prescale factor, then drives a period counter from the divided tick. The pin is active while that counter is below a programmed compare value. The resulting waveform repeats every (prescale+1)·(period+1) clocks. Software programs the channels through a simple synchronous register port. Writes are accepted in the cycle they are presented, with no back-pressure. Reads are combinational on the address.

Every register write raises a pending flag in a shared status word, and the flag drops when the written value reaches the counting logic. Software polls that flag before its next write. In autoload mode, new prescale, period and compare values wait in a shadow copy until the period counter wraps, so a running waveform never shows a torn period. Two one-shot control bits force an early transfer. A stop-immediately option selects between cutting the output at once and letting the current period finish.

Top module: `mmio_pwm`

## Requirements
- R1: After reset every register reads zero, the status word reads zero, and both pins are low.
- R2: Channel n occupies byte addresses n·0x10 to n·0x10+0xC. The offsets are +0x0 control, +0x4 prescale (10 bits), +0x8 period (12 bits) and +0xC compare (12 bits). Unused upper bits read zero. Slots 2 and 3, unaligned addresses and every other address read zero, and writes to them change nothing. Control bits are 0 enable, 1 invert, 2 autoload and 3 stop-immediately. Bits 4 and 5 are one-shot load strobes and read back as zero.
- R3: The status word at 0x40 holds the pending flags of channel n at bits 8n+0 (control), 8n+1 (prescale), 8n+2 (period) and 8n+3 (compare). A flag reads 1 in the cycle after its register is written. All other bits read zero, and writes to 0x40 are ignored.
- R4: The control pending flag clears one cycle after it is set, and the new control value takes effect on the counting logic in that same cycle.
- R5: When autoload is off or the channel is not running, a written prescale, period or compare value takes effect, and its flag clears, one cycle after the write.
- R6: When autoload is on and the channel is running, those values take effect, and their flags clear, on the clock edge where the period counter wraps.
- R7: A control write with bit 4 set forces a pending prescale transfer on the next cycle. Bit 5 does the same for pending period and compare values.
- R8: While running, the waveform period is (prescale+1)·(period+1) clocks, and the pin is active while the period count is below the compare value. A compare of 0 is never active. A compare above the period value is always active.
- R9: The invert bit flips the pin level, and an idle channel drives the inverted-inactive level.
- R10: Clearing enable with stop-immediately set idles the channel on the cycle the control value takes effect. Without it, the channel idles only at the end of the current period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe, accepted in the same cycle |
| reg_addr | input | 7 | Byte address of the register |
| reg_wdata | input | 12 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pwm_out | output | 2 | One waveform pin per channel |

## Verification
The channels are run with a compare inside the period, a compare of zero and a compare above the period. These three patterns separate a correct less-than compare from off-by-one or saturating variants. Updates are written with autoload off, with autoload on during a running period, and with the forced-load strobes. Watching the status word every cycle distinguishes immediate, deferred and forced transfer timing. The disable sequence is exercised with and without stop-immediately, which shows whether the period end is honoured. Channel 1 runs alongside channel 0 throughout, so any leak between the channels shows up.

// File: rtl/mmio_pwm_pkg.sv
package mmio_pwm_pkg;
  typedef enum logic [1:0] {
    OFS_CTRL = 2'd0,
    OFS_PRE  = 2'd1,
    OFS_PER  = 2'd2,
    OFS_CMP  = 2'd3
  } reg_ofs_e;

  typedef struct packed {
    logic stop_now;
    logic autoload;
    logic invert;
    logic enable;
  } ctrl_t;

  localparam int CTRL_W       = 4;
  localparam int BIT_LOAD_PRE = 4;
  localparam int BIT_LOAD_PER = 5;
  localparam int PEND_W       = 4;
  localparam int PEND_CTRL    = 0;
  localparam int PEND_PRE     = 1;
  localparam int PEND_PER     = 2;
  localparam int PEND_CMP     = 3;
endpackage

// File: rtl/mmio_pwm_chan_regs.sv
module mmio_pwm_chan_regs
  import mmio_pwm_pkg::*;
#(
  parameter int PRE_W = 10,
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_ofs_e         wr_ofs,
  input  logic [PER_W-1:0] wr_data,
  input  logic             run,
  input  logic             wrap,
  output ctrl_t            ctrl_q,
  output ctrl_t            ctrl_act,
  output logic [PRE_W-1:0] pre_sh,
  output logic [PER_W-1:0] per_sh,
  output logic [PER_W-1:0] cmp_sh,
  output logic [PRE_W-1:0] pre_act,
  output logic [PER_W-1:0] per_act,
  output logic [PER_W-1:0] cmp_act,
  output logic [PEND_W-1:0] pend
);
  logic force_pre, force_per, hold;

  // Deferred transfer only while running in autoload mode and not at a wrap.
  assign hold = ctrl_act.autoload && run && !wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      ctrl_act  <= '0;
      force_pre <= 1'b0;
      force_per <= 1'b0;
      pre_sh    <= '0;
      per_sh    <= '0;
      cmp_sh    <= '0;
      pre_act   <= '0;
      per_act   <= '0;
      cmp_act   <= '0;
      pend      <= '0;
    end else begin
      ctrl_act        <= ctrl_q;
      pend[PEND_CTRL] <= 1'b0;
      force_pre       <= 1'b0;
      force_per       <= 1'b0;
      if (pend[PEND_PRE] && (!hold || force_pre)) begin
        pre_act        <= pre_sh;
        pend[PEND_PRE] <= 1'b0;
      end
      if (pend[PEND_PER] && (!hold || force_per)) begin
        per_act        <= per_sh;
        pend[PEND_PER] <= 1'b0;
      end
      if (pend[PEND_CMP] && (!hold || force_per)) begin
        cmp_act        <= cmp_sh;
        pend[PEND_CMP] <= 1'b0;
      end
      if (wr_en) begin
        unique case (wr_ofs)
          OFS_CTRL: begin
            ctrl_q          <= ctrl_t'(wr_data[CTRL_W-1:0]);
            force_pre       <= wr_data[BIT_LOAD_PRE];
            force_per       <= wr_data[BIT_LOAD_PER];
            pend[PEND_CTRL] <= 1'b1;
          end
          OFS_PRE: begin
            pre_sh         <= wr_data[PRE_W-1:0];
            pend[PEND_PRE] <= 1'b1;
          end
          OFS_PER: begin
            per_sh         <= wr_data;
            pend[PEND_PER] <= 1'b1;
          end
          default: begin
            cmp_sh         <= wr_data;
            pend[PEND_CMP] <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/mmio_pwm_chan_core.sv
module mmio_pwm_chan_core #(
  parameter int PRE_W = 10,
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             stop_now,
  input  logic             invert,
  input  logic [PRE_W-1:0] pre_act,
  input  logic [PER_W-1:0] per_act,
  input  logic [PER_W-1:0] cmp_act,
  output logic             run,
  output logic             wrap,
  output logic             pin
);
  logic [PRE_W-1:0] div_cnt;
  logic [PER_W-1:0] per_cnt;
  logic             tick;

  assign tick = (div_cnt == pre_act);
  assign wrap = run && tick && (per_cnt == per_act);
  assign pin  = (run && (per_cnt < cmp_act)) ^ invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      div_cnt <= '0;
      per_cnt <= '0;
    end else if (!run) begin
      div_cnt <= '0;
      per_cnt <= '0;
      if (enable) run <= 1'b1;
    end else if (!enable && (stop_now || wrap)) begin
      run     <= 1'b0;
      div_cnt <= '0;
      per_cnt <= '0;
    end else if (tick) begin
      div_cnt <= '0;
      per_cnt <= wrap ? '0 : per_cnt + 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mmio_pwm.sv
module mmio_pwm
  import mmio_pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 10,
  parameter int PER_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [PER_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int OFS_LSB   = 2;
  localparam int SLOT_LSB  = 4;
  localparam int SLOT_W    = 2;
  localparam int STAT_BIT  = SLOT_LSB + SLOT_W;
  localparam int STAT_LANE = 8;
  localparam int REGS_PER  = 4;

  logic              aligned, is_chan, is_status;
  logic [SLOT_W-1:0] slot;
  logic [1:0]        ofs;

  assign aligned   = (reg_addr[OFS_LSB-1:0] == '0);
  assign is_chan   = aligned && !reg_addr[STAT_BIT];
  assign is_status = aligned && reg_addr[STAT_BIT] && (reg_addr[STAT_BIT-1:OFS_LSB] == '0);
  assign slot      = reg_addr[SLOT_LSB +: SLOT_W];
  assign ofs       = reg_addr[OFS_LSB +: 2];

  logic [PEND_W-1:0]        pend [NUM_CH];
  logic [DATA_W-1:0]        chan_rd [NUM_CH][REGS_PER];
  logic [NUM_CH-1:0]        chan_run;
  logic [NUM_CH*PEND_W-1:0] pend_vec;

  for (genvar g = 0; g < NUM_CH; g++) begin : gen_ch
    ctrl_t            ctrl_q, ctrl_act;
    logic [PRE_W-1:0] pre_sh, pre_act;
    logic [PER_W-1:0] per_sh, per_act, cmp_sh, cmp_act;
    logic             run, wrap, sel;

    assign sel = reg_we && is_chan && (slot == SLOT_W'(g));

    mmio_pwm_chan_regs #(.PRE_W(PRE_W), .PER_W(PER_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (sel),
      .wr_ofs   (reg_ofs_e'(ofs)),
      .wr_data  (reg_wdata),
      .run      (run),
      .wrap     (wrap),
      .ctrl_q   (ctrl_q),
      .ctrl_act (ctrl_act),
      .pre_sh   (pre_sh),
      .per_sh   (per_sh),
      .cmp_sh   (cmp_sh),
      .pre_act  (pre_act),
      .per_act  (per_act),
      .cmp_act  (cmp_act),
      .pend     (pend[g])
    );

    mmio_pwm_chan_core #(.PRE_W(PRE_W), .PER_W(PER_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (ctrl_act.enable),
      .stop_now (ctrl_act.stop_now),
      .invert   (ctrl_act.invert),
      .pre_act  (pre_act),
      .per_act  (per_act),
      .cmp_act  (cmp_act),
      .run      (run),
      .wrap     (wrap),
      .pin      (pwm_out[g])
    );

    assign chan_rd[g][OFS_CTRL] = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
    assign chan_rd[g][OFS_PRE]  = {{(DATA_W-PRE_W){1'b0}}, pre_sh};
    assign chan_rd[g][OFS_PER]  = {{(DATA_W-PER_W){1'b0}}, per_sh};
    assign chan_rd[g][OFS_CMP]  = {{(DATA_W-PER_W){1'b0}}, cmp_sh};
    assign chan_run[g]                 = run;
    assign pend_vec[g*PEND_W +: PEND_W] = pend[g];
  end

  always_comb begin
    reg_rdata = '0;
    if (is_status) begin
      for (int c = 0; c < NUM_CH; c++) reg_rdata[c*STAT_LANE +: PEND_W] = pend[c];
    end else if (is_chan) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (slot == SLOT_W'(c)) reg_rdata = chan_rd[c][ofs];
      end
    end
  end
endmodule

// File: rtl/mmio_pwm_checker.sv
module mmio_pwm_checker #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_we,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [DATA_W-1:0]   reg_rdata,
  input logic [NUM_CH-1:0]   chan_run,
  input logic [NUM_CH*4-1:0] pend_vec
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(64);

  function automatic logic [DATA_W-1:0] live_mask();
    logic [DATA_W-1:0] m = '0;
    for (int c = 0; c < NUM_CH; c++) m[c*8 +: 4] = 4'hF;
    return m;
  endfunction
  localparam logic [DATA_W-1:0] LIVE = live_mask();

  // R3: spare status bits read zero
  a_r3_status_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == STAT_ADDR) |-> ((reg_rdata & ~LIVE) == '0));

  // R2: absent channel slots read zero
  a_r2_absent_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_addr[6] && (int'(reg_addr[5:4]) >= NUM_CH)) |-> (reg_rdata == '0));

  for (genvar g = 0; g < NUM_CH; g++) begin : gen_chk
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(g*16);
    localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(g*16 + 8);
    localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(g*16 + 12);

    // R4
    a_r4_ctrl_pend_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_vec[4*g] && !(reg_we && reg_addr == A_CTRL)) |=> !pend_vec[4*g]);

    // R3
    a_r3_cmp_write_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_CMP) |=> pend_vec[4*g+3]);

    // R5
    a_r5_idle_period_applies: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_vec[4*g+2] && !chan_run[g] && !(reg_we && reg_addr == A_PER))
        |=> !pend_vec[4*g+2]);
  end
endmodule

bind mmio_pwm mmio_pwm_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .chan_run  (chan_run),
  .pend_vec  (pend_vec)
);

// File: tb/mmio_pwm_tb_top.sv
module mmio_pwm_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [6:0]  addr = 7'h40;
  logic [11:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  pwm_out;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  int m_ctrl[2], m_cact[2], m_force[2], m_pend[2];
  int m_sh[2][3], m_act[2][3];
  int m_run[2], m_pc[2], m_cnt[2];

  mmio_pwm dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int model_read(int a);
    int s;
    if (a == 'h40) begin
      s = 0;
      for (int c = 0; c < 2; c++) s |= m_pend[c] << (8*c);
      return s;
    end
    if (a < 'h40 && (a & 3) == 0 && ((a >> 4) & 3) < 2) begin
      case ((a >> 2) & 3)
        0: return m_ctrl[(a >> 4) & 3];
        1: return m_sh[(a >> 4) & 3][0];
        2: return m_sh[(a >> 4) & 3][1];
        default: return m_sh[(a >> 4) & 3][2];
      endcase
    end
    return 0;
  endfunction

  function automatic int model_pin(int c);
    int act;
    act = (m_run[c] != 0 && m_cnt[c] < m_act[c][2]) ? 1 : 0;
    return act ^ ((m_cact[c] >> 1) & 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_ctrl[c] = 0; m_cact[c] = 0; m_force[c] = 0; m_pend[c] = 0;
        m_run[c] = 0; m_pc[c] = 0; m_cnt[c] = 0;
        for (int k = 0; k < 3; k++) begin m_sh[c][k] = 0; m_act[c][k] = 0; end
      end
    end else begin
      cyc++;
      for (int c = 0; c < 2; c++) begin
        int en, al, stp, wrap, hold, was_run, wd;
        en   = m_cact[c] & 1;
        al   = (m_cact[c] >> 2) & 1;
        stp  = (m_cact[c] >> 3) & 1;
        was_run = m_run[c];
        wrap = (m_run[c] != 0 && m_pc[c] == m_act[c][0] && m_cnt[c] == m_act[c][1]) ? 1 : 0;
        hold = (al != 0 && was_run != 0 && wrap == 0) ? 1 : 0;
        // counting: R8 / R10
        if (m_run[c] == 0) begin
          if (en != 0) m_run[c] = 1;
        end else if (en == 0 && (stp != 0 || wrap != 0)) begin
          m_run[c] = 0; m_pc[c] = 0; m_cnt[c] = 0;
        end else if (m_pc[c] == m_act[c][0]) begin
          m_pc[c] = 0;
          m_cnt[c] = (wrap != 0) ? 0 : m_cnt[c] + 1;
        end else begin
          m_pc[c]++;
        end
        // transfers: R5 / R6 / R7
        for (int k = 0; k < 3; k++) begin
          int fb;
          fb = (k == 0) ? (m_force[c] & 1) : ((m_force[c] >> 1) & 1);
          if (((m_pend[c] >> (k+1)) & 1) != 0 && (hold == 0 || fb != 0)) begin
            m_act[c][k] = m_sh[c][k];
            m_pend[c] &= ~(1 << (k+1));
          end
        end
        m_pend[c] &= ~1;
        m_cact[c]  = m_ctrl[c];
        m_force[c] = 0;
        wd = int'(wdata);
        if (we && addr < 7'h40 && addr[1:0] == 2'b00 && int'(addr[5:4]) == c) begin
          case (addr[3:2])
            2'd0: begin m_ctrl[c] = wd & 15; m_force[c] = (wd >> 4) & 3; m_pend[c] |= 1; end
            2'd1: begin m_sh[c][0] = wd & 1023; m_pend[c] |= 2; end
            2'd2: begin m_sh[c][1] = wd & 4095; m_pend[c] |= 4; end
            default: begin m_sh[c][2] = wd & 4095; m_pend[c] |= 8; end
          endcase
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < 2; c++)
        check(int'(pwm_out[c]) == model_pin(c), cur_req, pwm_out[c], model_pin(c));
      check(int'(rdata) == model_read(int'(addr)), cur_req, rdata, model_read(int'(addr)));
    end
  end

  always @(posedge clk) begin
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cyc, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr(logic [6:0] a, logic [11:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0; addr = 7'h40;
  endtask

  task automatic peek(logic [6:0] a);
    @(posedge clk); #1;
    addr = a;
    @(posedge clk); #1;
    addr = 7'h40;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    int t0, t1;
    // R1: reset values on every address and both pins
    cur_req = "R1";
    check(pwm_out == 2'b00, "R1", pwm_out, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int a = 0; a <= 'h4C; a += 4) peek(7'(a));

    // R2: field widths, strobe bits, absent slots, unaligned, status writes
    cur_req = "R2";
    wr(7'h14, 12'hFFF);
    wr(7'h10, 12'h03E);
    for (int a = 'h10; a <= 'h1C; a += 4) peek(7'(a));
    wr(7'h20, 12'hABC);
    peek(7'h20);
    wr(7'h31, 12'h123);
    peek(7'h30);
    peek(7'h31);
    cur_req = "R3";
    wr(7'h40, 12'hFFF);
    peek(7'h40);
    wr(7'h10, 12'h000);
    wr(7'h14, 12'h000);
    idle(3);

    // R5: idle channel takes values one cycle after each write
    cur_req = "R5";
    wr(7'h04, 12'd1);
    wr(7'h08, 12'd4);
    wr(7'h0C, 12'd2);
    idle(3);

    // R4: enabling
    cur_req = "R4";
    wr(7'h00, 12'h001);
    idle(5);

    // R8: waveform period (1+1)*(4+1) = 10
    cur_req = "R8";
    @(posedge pwm_out[0]); t0 = cyc;
    @(posedge pwm_out[0]); t1 = cyc;
    check(t1 - t0 == 10, "R8 period", t1 - t0, 10);
    // channel 1 with compare above period: always active
    wr(7'h18, 12'd2);
    wr(7'h1C, 12'd3);
    wr(7'h10, 12'h001);
    idle(12);

    // R6: autoload defers until wrap
    cur_req = "R6";
    wr(7'h00, 12'h005);
    wr(7'h0C, 12'd4);
    idle(25);
    wr(7'h08, 12'd3);
    idle(25);

    // R7: forced period/compare transfer
    cur_req = "R7";
    wr(7'h0C, 12'd1);
    wr(7'h08, 12'd6);
    wr(7'h00, 12'h025);
    idle(20);
    wr(7'h04, 12'd0);
    wr(7'h00, 12'h015);
    idle(20);

    // R9: invert, also on channel 1
    cur_req = "R9";
    wr(7'h00, 12'h007);
    idle(20);
    wr(7'h10, 12'h003);
    idle(10);
    wr(7'h10, 12'h002);
    idle(6);

    // R8: compare of zero and compare above period
    cur_req = "R8";
    wr(7'h00, 12'h001);
    wr(7'h0C, 12'd0);
    idle(20);
    wr(7'h0C, 12'hFFF);
    idle(20);

    // R10: stop immediately versus finishing the period
    cur_req = "R10";
    wr(7'h04, 12'd1);
    wr(7'h0C, 12'd3);
    wr(7'h00, 12'h009);
    idle(5);
    wr(7'h00, 12'h008);
    idle(10);
    wr(7'h00, 12'h001);
    idle(7);
    wr(7'h00, 12'h000);
    idle(30);
    peek(7'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule